// File: doc/BRIEF.md
# Branch-guard invalidation tracker

A small direct-mapped fetch buffer can promise that the target of a direct branch is already resident, keeping one "target guaranteed" flag per instruction slot. Once the line holding a target leaves the buffer, every branch whose flag points into that line must lose its flag. This block keeps, for each buffer line, a summary of the branch slots that were given a guarantee into that line. When a line is evicted or invalidated, it returns the set of slot flags to clear.

The summary takes one of four forms, picked by a mode input. In oblivious mode nothing is recorded and every eviction clears all flags. In exact-slot mode each line has one bit per source slot. In source-line mode each line has one bit per source line. In Bloom mode each line has a 12-bit filter written through four fixed hashes of the slot index. A summary is never thinned bit by bit; it is emptied as a whole when its own line leaves. Stale entries can therefore cause extra clears (false positives) but never a missed clear. Events are one-cycle strobes with no back-pressure: in each cycle the tracker accepts one set event and one evict event, and its only data output is the combinational clear mask for the evict strobe of that cycle.

Top module: `branch_guard_tracker`

## Requirements
- R1: After reset every line summary is empty, so in any mode other than oblivious an eviction returns an all-zero mask.
- R2: In a cycle with `evict_valid` low, `clear_mask` is all zero.
- R3: Mode 2'b00 (oblivious): every eviction returns an all-ones mask, and set events have no visible effect.
- R4: Mode 2'b01 (exact-slot): the mask for line L has bit s set exactly for the slots s recorded into L since L was last cleared.
- R5: Mode 2'b10 (source-line): a set of slot s records source line s/4. The mask sets every slot whose source line was recorded into L.
- R6: Mode 2'b11 (Bloom): with x the 5-bit slot index, the filter positions are x mod 12, (x XOR 5'h16) mod 12, rotate-left-1(x) mod 12, and (rotate-left-3(x) XOR 5'h0B) mod 12. The mask sets every slot whose four positions are all set in L's filter.
- R7: In every recording mode, a slot recorded into L is always in the mask of the next eviction of L (no false negatives).
- R8: An eviction empties the line's whole summary on the next clock edge, so an immediate second eviction of that line returns zero.
- R9: When a set and an eviction target the same line in the same cycle, the eviction wins and the set is dropped. A set to a different line in that cycle is still recorded.
- R10: The mask is valid combinationally in the same cycle as the `evict_valid` strobe. It reflects only sets applied at earlier clock edges.
- R11: Sets into a line accumulate. Repeating a set is harmless, and sets into other lines do not change line L's mask.
- R12: `mode` is held constant while out of reset. It is changed only under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Summary form: 00 oblivious, 01 exact-slot, 10 source-line, 11 Bloom |
| set_valid | input | 1 | Strobe: a branch's target guarantee was granted |
| set_slot | input | 5 | Global slot index of the branch (line*4 + position) |
| set_line | input | 3 | Buffer line holding the branch's target |
| evict_valid | input | 1 | Strobe: a line is evicted or invalidated |
| evict_line | input | 3 | Line being removed |
| clear_mask | output | 32 | Slot flags to clear, one bit per slot |

## Verification
The tracker is run in all four modes. In each mode, slots are recorded into one line and then removed. Exact-slot mode gives a tight check of which sources were recorded. Source-line mode shows the widening from one slot to all slots of its line. Bloom mode is run with slot pairs whose hash positions overlap, which brings out false positives that the other modes do not produce. Same-cycle set and evict patterns, to the same line and to different lines, separate the priority rule from ordinary recording. Back-to-back evictions of one line show that the summary is emptied in bulk.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
  typedef enum logic [1:0] {
    TRK_OBLIVIOUS = 2'b00,
    TRK_PER_SLOT  = 2'b01,
    TRK_PER_LINE  = 2'b10,
    TRK_BLOOM     = 2'b11
  } trk_mode_e;

  localparam int NUM_HASH = 4;
endpackage

// File: rtl/bgt_sig_encode.sv
module bgt_sig_encode
  import bgt_pkg::*;
#(
  parameter int SLOTS_PER_LINE = 4,
  parameter int BLOOM_BITS     = 12,
  parameter int FIELD_W        = 32,
  parameter int SLOT_W         = 5
) (
  input  logic [SLOT_W-1:0]  slot,
  input  trk_mode_e          mode,
  output logic [FIELD_W-1:0] sig
);
  localparam logic [SLOT_W-1:0] HK1 = SLOT_W'(22);
  localparam logic [SLOT_W-1:0] HK3 = SLOT_W'(11);

  function automatic logic [SLOT_W-1:0] rotl(input logic [SLOT_W-1:0] v, input int n);
    return (v << n) | (v >> (SLOT_W - n));
  endfunction

  logic [SLOT_W-1:0]  mixed;
  logic [FIELD_W-1:0] bloom_vec;

  always_comb begin
    bloom_vec = '0;
    mixed     = '0;
    for (int k = 0; k < NUM_HASH; k++) begin
      case (k)
        0:       mixed = slot;
        1:       mixed = slot ^ HK1;
        2:       mixed = rotl(slot, 1);
        default: mixed = rotl(slot, 3) ^ HK3;
      endcase
      bloom_vec[int'(mixed) % BLOOM_BITS] = 1'b1;
    end
  end

  always_comb begin
    case (mode)
      TRK_PER_SLOT: sig = FIELD_W'(1) << int'(slot);
      TRK_PER_LINE: sig = FIELD_W'(1) << (int'(slot) / SLOTS_PER_LINE);
      TRK_BLOOM:    sig = bloom_vec;
      default:      sig = '0;
    endcase
  end
endmodule

// File: rtl/bgt_field_store.sv
module bgt_field_store #(
  parameter int NUM_LINES = 8,
  parameter int FIELD_W   = 32,
  parameter int LINE_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [LINE_W-1:0]  set_line,
  input  logic [FIELD_W-1:0] set_sig,
  input  logic               clr_en,
  input  logic [LINE_W-1:0]  clr_line,
  output logic [FIELD_W-1:0] rd_field
);
  logic [FIELD_W-1:0] field_q [NUM_LINES];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        field_q[l] <= '0;
      end else if (clr_en && clr_line == LINE_W'(l)) begin
        field_q[l] <= '0;
      end else if (set_en && set_line == LINE_W'(l)) begin
        field_q[l] <= field_q[l] | set_sig;
      end
    end
  end

  assign rd_field = field_q[clr_line];
endmodule

// File: rtl/bgt_mask_gen.sv
module bgt_mask_gen
  import bgt_pkg::*;
#(
  parameter int NUM_SLOTS      = 32,
  parameter int SLOTS_PER_LINE = 4,
  parameter int BLOOM_BITS     = 12,
  parameter int FIELD_W        = 32,
  parameter int SLOT_W         = 5
) (
  input  trk_mode_e            mode,
  input  logic                 evict_valid,
  input  logic [FIELD_W-1:0]   field,
  output logic [NUM_SLOTS-1:0] mask
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [FIELD_W-1:0] probe;
    logic               member;

    bgt_sig_encode #(
      .SLOTS_PER_LINE(SLOTS_PER_LINE),
      .BLOOM_BITS    (BLOOM_BITS),
      .FIELD_W       (FIELD_W),
      .SLOT_W        (SLOT_W)
    ) u_probe (
      .slot(SLOT_W'(s)),
      .mode(mode),
      .sig (probe)
    );

    assign member  = (|probe) && ((probe & ~field) == '0);
    assign mask[s] = evict_valid && ((mode == TRK_OBLIVIOUS) || member);
  end
endmodule

// File: rtl/branch_guard_tracker.sv
module branch_guard_tracker
  import bgt_pkg::*;
#(
  parameter int NUM_LINES      = 8,
  parameter int SLOTS_PER_LINE = 4,
  parameter int BLOOM_BITS     = 12,
  localparam int NUM_SLOTS     = NUM_LINES * SLOTS_PER_LINE,
  localparam int SLOT_W        = $clog2(NUM_SLOTS),
  localparam int LINE_W        = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 set_valid,
  input  logic [SLOT_W-1:0]    set_slot,
  input  logic [LINE_W-1:0]    set_line,
  input  logic                 evict_valid,
  input  logic [LINE_W-1:0]    evict_line,
  output logic [NUM_SLOTS-1:0] clear_mask
);
  localparam int BIG_A   = (NUM_SLOTS > NUM_LINES) ? NUM_SLOTS : NUM_LINES;
  localparam int FIELD_W = (BIG_A > BLOOM_BITS) ? BIG_A : BLOOM_BITS;

  trk_mode_e          mode_e;
  logic [FIELD_W-1:0] set_sig;
  logic [FIELD_W-1:0] evict_field;

  assign mode_e = trk_mode_e'(mode);

  bgt_sig_encode #(
    .SLOTS_PER_LINE(SLOTS_PER_LINE),
    .BLOOM_BITS    (BLOOM_BITS),
    .FIELD_W       (FIELD_W),
    .SLOT_W        (SLOT_W)
  ) u_set_sig (
    .slot(set_slot),
    .mode(mode_e),
    .sig (set_sig)
  );

  bgt_field_store #(
    .NUM_LINES(NUM_LINES),
    .FIELD_W  (FIELD_W),
    .LINE_W   (LINE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_valid),
    .set_line(set_line),
    .set_sig (set_sig),
    .clr_en  (evict_valid),
    .clr_line(evict_line),
    .rd_field(evict_field)
  );

  bgt_mask_gen #(
    .NUM_SLOTS     (NUM_SLOTS),
    .SLOTS_PER_LINE(SLOTS_PER_LINE),
    .BLOOM_BITS    (BLOOM_BITS),
    .FIELD_W       (FIELD_W),
    .SLOT_W        (SLOT_W)
  ) u_mask (
    .mode       (mode_e),
    .evict_valid(evict_valid),
    .field      (evict_field),
    .mask       (clear_mask)
  );
endmodule

// File: rtl/bgt_tracker_chk.sv
module bgt_tracker_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5,
  parameter int LINE_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 set_valid,
  input logic [SLOT_W-1:0]    set_slot,
  input logic [LINE_W-1:0]    set_line,
  input logic                 evict_valid,
  input logic [LINE_W-1:0]    evict_line,
  input logic [NUM_SLOTS-1:0] clear_mask
);
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |-> clear_mask == '0); // R2

  AST_OBLIVIOUS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && mode == 2'b00) |-> (&clear_mask)); // R3

  AST_NO_FALSE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && mode != 2'b00 && !(evict_valid && evict_line == set_line))
    |=> (!(evict_valid && evict_line == $past(set_line)) || clear_mask[$past(set_slot)])); // R7

  AST_BULK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && mode != 2'b00)
    |=> (!(evict_valid && evict_line == $past(evict_line)) || clear_mask == '0)); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode)); // R12
endmodule

bind branch_guard_tracker bgt_tracker_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W),
  .LINE_W   (LINE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .set_valid  (set_valid),
  .set_slot   (set_slot),
  .set_line   (set_line),
  .evict_valid(evict_valid),
  .evict_line (evict_line),
  .clear_mask (clear_mask)
);

// File: tb/tb_branch_guard_tracker.sv
module tb_branch_guard_tracker;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_OBL  = 2'b00;
  localparam logic [1:0] M_SLOT = 2'b01;
  localparam logic [1:0] M_LINE = 2'b10;
  localparam logic [1:0] M_BLM  = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = M_OBL;
  logic        set_valid = 1'b0;
  logic [4:0]  set_slot = '0;
  logic [2:0]  set_line = '0;
  logic        evict_valid = 1'b0;
  logic [2:0]  evict_line = '0;
  logic [31:0] clear_mask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] rec [8];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_guard_tracker dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .set_valid(set_valid), .set_slot(set_slot), .set_line(set_line),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .clear_mask(clear_mask)
  );

  function automatic logic [11:0] bhash(input int s);
    logic [4:0]  v;
    logic [4:0]  h [4];
    logic [11:0] r;
    v = 5'(s);
    h[0] = v;
    h[1] = v ^ 5'h16;
    h[2] = {v[3:0], v[4]};
    h[3] = {v[1:0], v[4:2]} ^ 5'h0B;
    r = '0;
    for (int k = 0; k < 4; k++) r[int'(h[k]) % 12] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] expect_mask(input int ln);
    logic [31:0] m;
    logic [11:0] u;
    m = '0;
    u = '0;
    case (mode)
      M_OBL:  m = '1;
      M_SLOT: m = rec[ln];
      M_LINE: begin
        for (int s = 0; s < 32; s++)
          for (int r = 0; r < 32; r++)
            if (rec[ln][r] && (r / 4) == (s / 4)) m[s] = 1'b1;
      end
      default: begin
        for (int r = 0; r < 32; r++) if (rec[ln][r]) u = u | bhash(r);
        for (int s = 0; s < 32; s++)
          if (rec[ln] != '0 && (bhash(s) & ~u) == '0) m[s] = 1'b1;
      end
    endcase
    return m;
  endfunction

  // driver: one cycle of stimulus, expected mask pushed to the scoreboard
  task automatic cyc(input bit sv, input int ss, input int sl,
                     input bit ev, input int el, input string tag);
    @(negedge clk);
    set_valid   = sv;
    set_slot    = 5'(ss);
    set_line    = 3'(sl);
    evict_valid = ev;
    evict_line  = 3'(el);
    if (ev) begin
      exp_q.push_back(expect_mask(el));
      tag_q.push_back(tag);
    end
    if (ev) rec[el] = '0;
    if (sv && !(ev && el == sl) && mode != M_OBL) rec[sl][ss] = 1'b1;
  endtask

  task automatic idle();
    cyc(1'b0, 0, 0, 1'b0, 0, "R2");
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    set_valid = 1'b0;
    evict_valid = 1'b0;
    mode = m;
    for (int l = 0; l < 8; l++) rec[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: samples a quarter period after the driver's edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      if (evict_valid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R10: mask %h with no expectation queued (expected none)", clear_mask);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (clear_mask !== e) begin
            bad++;
            $display("FAIL %s: line %0d mask actual=%h expected=%h", t, evict_line, clear_mask, e);
          end
        end
      end else begin
        total++;
        if (clear_mask !== '0) begin
          bad++;
          $display("FAIL R2: idle mask actual=%h expected=00000000", clear_mask);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // exact-slot mode
    do_reset(M_SLOT);
    for (int l = 0; l < 8; l++) cyc(1'b0, 0, 0, 1'b1, l, "R1");
    cyc(1'b1, 5, 2, 1'b0, 0, "R4");
    cyc(1'b1, 17, 2, 1'b0, 0, "R4");
    cyc(1'b1, 17, 2, 1'b0, 0, "R11");
    cyc(1'b1, 30, 6, 1'b0, 0, "R11");
    idle();
    cyc(1'b0, 0, 0, 1'b1, 2, "R4");
    cyc(1'b0, 0, 0, 1'b1, 2, "R8");
    cyc(1'b1, 9, 6, 1'b1, 6, "R9");
    cyc(1'b0, 0, 0, 1'b1, 6, "R9");
    cyc(1'b1, 3, 1, 1'b1, 4, "R9");
    cyc(1'b0, 0, 0, 1'b1, 1, "R10");
    cyc(1'b1, 12, 0, 1'b0, 0, "R10");
    cyc(1'b0, 0, 0, 1'b1, 0, "R10");
    idle();

    // source-line mode
    do_reset(M_LINE);
    cyc(1'b0, 0, 0, 1'b1, 3, "R1");
    cyc(1'b1, 5, 0, 1'b0, 0, "R5");
    cyc(1'b1, 30, 0, 1'b0, 0, "R5");
    cyc(1'b1, 13, 4, 1'b0, 0, "R11");
    cyc(1'b0, 0, 0, 1'b1, 0, "R5");
    cyc(1'b0, 0, 0, 1'b1, 4, "R7");
    cyc(1'b0, 0, 0, 1'b1, 4, "R8");
    idle();

    // Bloom mode
    do_reset(M_BLM);
    cyc(1'b0, 0, 0, 1'b1, 3, "R1");
    cyc(1'b1, 5, 3, 1'b0, 0, "R6");
    cyc(1'b1, 20, 3, 1'b0, 0, "R6");
    cyc(1'b0, 0, 0, 1'b1, 5, "R11");
    cyc(1'b0, 0, 0, 1'b1, 3, "R6");
    cyc(1'b0, 0, 0, 1'b1, 3, "R8");
    for (int s = 0; s < 32; s += 3) cyc(1'b1, s, 7, 1'b0, 0, "R7");
    cyc(1'b0, 0, 0, 1'b1, 7, "R7");
    cyc(1'b1, 1, 2, 1'b0, 0, "R6");
    cyc(1'b1, 2, 2, 1'b1, 2, "R9");
    cyc(1'b0, 0, 0, 1'b1, 2, "R9");
    idle();

    // oblivious mode
    do_reset(M_OBL);
    cyc(1'b0, 0, 0, 1'b1, 0, "R3");
    cyc(1'b1, 8, 5, 1'b0, 0, "R3");
    cyc(1'b0, 0, 0, 1'b1, 5, "R3");
    cyc(1'b0, 0, 0, 1'b1, 5, "R12");
    idle();
    idle();

    @(negedge clk);
    #(CLK_PERIOD/2);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R10: %0d expectations left, expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule